// File: doc/BRIEF.md
# Amplitude-Scaled Sine Sample Generator

This block turns a phase angle and an amplitude setting into one unsigned sample of a sine wave. The sample is meant for the duty-cycle input of a pulse-width modulator. A built-in table holds one signed sine value for each phase code. The value the phase selects is multiplied by an unsigned amplitude. The top byte of the signed product is kept, and half scale is added so that the waveform sits around the middle of the output range.

The caller pulses `sample_stb` with `phase` and `amp` valid. One clock later the new sample appears on `samp_out`, and `samp_vld` is high for that single cycle. Between strobes the output keeps its last value. Phase accumulation and the modulator itself are outside this block.

Top module: `sine_amp_gen`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `samp_out` is 0x80 and `samp_vld` is 0.
- R2: The table entry for phase code i (0..255) is T(i) = round(127*sin(2*pi*i/256)), held as a signed 8-bit value. A strobed sample equals (floor(T(phase)*amp/256) + 128) mod 256, where `amp` is unsigned 0..255.
- R3: `samp_out` and `samp_vld` change at the clock edge that samples `sample_stb` high. `samp_vld` is high in the cycle after every strobe and low in every other cycle.
- R4: With `amp` equal to 0, every phase gives exactly 0x80.
- R5: In a cycle with no strobe, `samp_out` keeps its value even when `phase` and `amp` change.
- R6: The product is truncated toward minus infinity and is not rounded. Phase 129 (T=-3) with amp 1 gives 0x7F. Phase 192 (T=-127) with amp 255 gives 0x01. Phase 64 (T=127) with amp 255 gives 0xFE. The offset is added modulo 256 with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Request a new sample this cycle |
| phase | input | 8 | Phase angle code, 256 steps per period |
| amp | input | 8 | Unsigned amplitude, 0..255 |
| samp_out | output | 8 | Registered offset sample |
| samp_vld | output | 1 | One-cycle flag for a new sample |

## Verification
The hardest case to reach is a small negative product, where floor truncation takes the result just below half scale instead of to it. Random stimulus rarely hits it. The bench therefore drives it on purpose: phase 129 with amplitude 1, and the negative peak at full amplitude. Around these it runs full sweeps of the phase at amplitudes 255 and 0, then random phase and amplitude values with sparse strobes. A behavioural integer model is compared with the outputs on every clock.

// File: rtl/sine_amp_gen.sv
module sine_amp_gen #(
  parameter int PH_W  = 8,
  parameter int AMP_W = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_stb,
  input  logic [PH_W-1:0]  phase,
  input  logic [AMP_W-1:0] amp,
  output logic [OUT_W-1:0] samp_out,
  output logic             samp_vld
);
  localparam int DEPTH = 1 << PH_W;
  localparam int PEAK  = (1 << (OUT_W-1)) - 1;
  localparam int PRD_W = OUT_W + AMP_W;
  localparam logic [OUT_W-1:0] MID = OUT_W'(1 << (OUT_W-1));
  localparam real TWO_PI = 6.283185307179586;

  function automatic logic signed [OUT_W-1:0] sine_at(input int i);
    real a;
    a = real'(PEAK) * $sin(TWO_PI * real'(i) / real'(DEPTH));
    return OUT_W'(a >= 0.0 ? $rtoi(a + 0.5) : $rtoi(a - 0.5));
  endfunction

  logic signed [OUT_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_rom
    assign rom[g] = sine_at(g);
  end

  logic signed [PRD_W-1:0] prod;
  logic        [OUT_W-1:0] nxt;

  assign prod = rom[phase] * $signed({1'b0, amp});
  assign nxt  = prod[PRD_W-1 -: OUT_W] + MID;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_out <= MID;
      samp_vld <= 1'b0;
    end else begin
      samp_vld <= sample_stb;
      if (sample_stb) samp_out <= nxt;
    end
  end

  AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |=> samp_vld); // R3
  AST_VLD_ONLY_STB: assert property (@(posedge clk) disable iff (!rst_n) !sample_stb |=> !samp_vld); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !sample_stb |=> $stable(samp_out)); // R5
  AST_ZERO_AMP_MID: assert property (@(posedge clk) disable iff (!rst_n) (sample_stb && amp == '0) |=> samp_out == MID); // R4
  AST_NEVER_RAIL: assert property (@(posedge clk) disable iff (!rst_n) samp_vld |-> (samp_out != '0 && samp_out != '1)); // R6
endmodule

// File: tb/sine_amp_gen_bench.sv
`timescale 1ns/1ps
module sine_amp_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_stb = 1'b0;
  logic [7:0] phase = '0;
  logic [7:0] amp = '0;
  logic [7:0] samp_out;
  logic samp_vld;

  int n_checks = 0;
  int n_fail = 0;
  string cur_req = "R1";
  int m_out = 128;
  int m_vld = 0;

  always #10 clk = ~clk;

  sine_amp_gen u_sine_amp_gen (
    .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
    .phase(phase), .amp(amp), .samp_out(samp_out), .samp_vld(samp_vld)
  );

  function automatic int tbl(input int i);
    real a;
    a = 127.0 * $sin(2.0 * 3.141592653589793 * i / 256.0);
    return (a >= 0.0) ? $rtoi(a + 0.5) : $rtoi(a - 0.5);
  endfunction

  function automatic int expect_sample(input int ph, input int am);
    int p;
    p = tbl(ph) * am;
    return ((p >>> 8) + 128) & 255;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 128;
      m_vld = 0;
    end else begin
      m_vld = sample_stb ? 1 : 0;
      if (sample_stb) m_out = expect_sample(phase, amp);
    end
  end

  task automatic check_now();
    n_checks++;
    if (int'(samp_out) != m_out) begin
      n_fail++;
      $display("FAIL %s samp_out actual %0d expected %0d", cur_req, samp_out, m_out);
    end
    n_checks++;
    if (int'(samp_vld) != m_vld) begin
      n_fail++;
      $display("FAIL R3 samp_vld actual %0d expected %0d", samp_vld, m_vld);
    end
  endtask

  task automatic step(input logic s, input int ph, input int am);
    @(negedge clk);
    check_now();
    sample_stb = s;
    phase = 8'(ph);
    amp = 8'(am);
  endtask

  task automatic fixed(input int ph, input int am, input int want);
    step(1'b1, ph, am);
    step(1'b0, 0, 0);
    n_checks++;
    if (int'(samp_out) != want) begin
      n_fail++;
      $display("FAIL R6 phase %0d amp %0d actual %0d expected %0d", ph, am, samp_out, want);
    end
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) step(1'b1, 64, 255);
    step(1'b0, 0, 0);
    rst_n = 1'b1;
    step(1'b0, 0, 0);
    cur_req = "R2";
    for (int i = 0; i < 256; i++) step(1'b1, i, 255);
    cur_req = "R3";
    for (int i = 0; i < 40; i++) step(1'(i % 3 == 0), i * 7, 200);
    cur_req = "R4";
    for (int i = 0; i < 256; i++) step(1'b1, i, 0);
    cur_req = "r6_";
    fixed(129, 1, 8'h7F);
    fixed(192, 255, 8'h01);
    fixed(64, 255, 8'hFE);
    fixed(0, 255, 8'h80);
    cur_req = "R5";
    for (int i = 0; i < 2000; i++)
      step(1'($urandom_range(0, 3) == 0), $urandom_range(0, 255), $urandom_range(0, 255));
    cur_req = "R2";
    for (int i = 0; i < 2000; i++)
      step(1'b1, $urandom_range(0, 255), $urandom_range(0, 255));
    step(1'b0, 0, 0);
    step(1'b0, 0, 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule